// File: doc/BRIEF.md
# Neighbourhood Pattern Fault Tester

This block is a self-test controller for a bit-wide memory laid out as a grid of `ROWS` x `COLS` cells. It looks for faults in which a cell's behaviour depends on the cells next to it. Each cell under test (the base) is considered together with the four cells that touch it on the north, east, south and west sides. Diagonal cells play no part.

The cells are split into two colours, like a chessboard. First the even cells are bases and the odd cells serve as neighbours. Then the roles swap. For every base cell, the controller steps through all sixteen patterns of its four neighbours in a Gray order, so each step rewrites only one neighbour. After each step it reads the base and also writes it to both values and reads it back.

The controller drives a synchronous single-port RAM port. If a read disagrees with the value it expects, the controller stops and holds the cell position, the expected bit and the neighbour pattern. If every read agrees, it ends with pass.

Top module: `nps_bist_ctrl`

## Requirements
- R1: After reset `done`, `pass` and `fail` are 0 and `mem_we` is 0. No memory access starts until `start` is seen high.
- R2: A test starts on a `start` pulse seen while the controller is idle or finished. It then writes 0 to every cell of the array once, before any base is swept. The address is `{row, col}`, with the row in the upper `RW` bits and the column in the lower `CW` bits.
- R3: Bases are swept in two groups, one after the other. Group 0 contains the cells where row+col is even, and group 1 the cells where it is odd. Within a group, bases are taken in row-major order, with the column running fastest.
- R4: For each base, the controller runs two phases, first with the held value h=0 and then with h=1. Each phase starts with a write of h to the base. It then has 16 slots k=1..16. Slot k does the following, in order: write the one neighbour whose bit differs between gray(k-1) and gray(k mod 16); read the base and expect h; write !h; read and expect !h; write h; read and expect h. After the second phase the base is written back to 0.
- R5: The pattern of slot k is gray(k mod 16) = k ^ (k>>1). Bit 0 is north (row-1), bit 1 is east (col+1), bit 2 is south (row+1) and bit 3 is west (col-1). The neighbour write stores that bit of the new pattern.
- R6: A neighbour that lies outside the array is never written. Its slot keeps the same length but makes no write, and the base is still read in the usual way. No write ever leaves the array.
- R7: On the first read that returns a value other than expected, the following happen. No write is issued from that cycle on. `fail` and `done` rise, and `pass` stays 0. `fail_row`, `fail_col`, `fail_exp` and `fail_pat` hold the base row, the base column, the expected bit and the slot's pattern.
- R8: If both groups finish with no mismatch, `done` and `pass` rise and `fail` stays 0. While `done` is high, no write is issued.
- R9: `start` seen after a finished test, whether it passed or failed, clears the result and runs the whole test again from the array fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a test when the controller is idle or finished |
| mem_addr | output | RW+CW | Cell address `{row, col}` |
| mem_we | output | 1 | Write strobe for the current cycle |
| mem_wdata | output | 1 | Bit to write |
| mem_rdata | input | 1 | Bit read from the address of the previous cycle |
| done | output | 1 | Test has finished (pass or fail) |
| pass | output | 1 | Finished with no mismatch |
| fail | output | 1 | Stopped on a mismatch |
| fail_row | output | RW | Row of the failing base |
| fail_col | output | CW | Column of the failing base |
| fail_exp | output | 1 | Bit that the failing read expected |
| fail_pat | output | 4 | Neighbour pattern at the failing read |

## Verification
The bench uses a 6x5 array. With this size, a wrapped row or column minus one still forms a valid address field but points outside the grid. A controller that did not skip edge neighbours would therefore write to cells the memory model flags.

Faults are placed at the first corner and the last corner of the array, on both checkerboard colours. The fault types are stuck cells, a static fault that reacts only to the pattern 0101, and a transition fault triggered by a rising east neighbour. Each one can be caught only at one specific base, phase, slot and read. A controller with the wrong group parity, scan order, Gray order or bit mapping would report a different cell or pattern.

On a fault-free memory, the bench compares the total number of writes with a count worked out per cell from the edge rules. A sweep that drops or adds neighbour writes changes this total. After a failure, the bench confirms that no further write appears.

// File: rtl/nps_pkg.sv
package nps_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_INIT = 3'd1,
        ST_RUN  = 3'd2,
        ST_DONE = 3'd3,
        ST_FAIL = 3'd4
    } nps_state_e;

    // micro-operations inside one pattern slot, in issue order
    typedef enum logic [2:0] {
        OP_NBR_WR  = 3'd0,
        OP_RD_HOLD = 3'd1,
        OP_WR_FLIP = 3'd2,
        OP_RD_FLIP = 3'd3,
        OP_WR_BACK = 3'd4,
        OP_RD_BACK = 3'd5
    } nps_op_e;

    localparam logic [4:0] SLOT_PRE  = 5'd0;
    localparam logic [4:0] SLOT_LAST = 5'd16;
    localparam logic [4:0] SLOT_POST = 5'd17;

    function automatic logic [3:0] gray4(input logic [3:0] v);
        return v ^ (v >> 1);
    endfunction

endpackage

// File: rtl/nps_gray_step.sv
module nps_gray_step
    import nps_pkg::*;
(
    input  logic [4:0] slot,
    output logic [3:0] pat,
    output logic [1:0] dir
);
    logic [3:0] prev_idx;
    logic [3:0] flip;

    always_comb begin
        prev_idx = slot[3:0] - 4'd1;
        pat      = gray4(slot[3:0]);
        flip     = pat ^ gray4(prev_idx);
        dir      = 2'd0;
        for (int i = 0; i < 4; i++) begin
            if (flip[i]) dir = 2'(i);
        end
    end
endmodule

// File: rtl/nps_nbr_sel.sv
module nps_nbr_sel #(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    parameter int RW   = 3,
    parameter int CW   = 3
) (
    input  logic [RW-1:0] row,
    input  logic [CW-1:0] col,
    input  logic [1:0]    dir,
    output logic [RW-1:0] nrow,
    output logic [CW-1:0] ncol,
    output logic          valid
);
    always_comb begin
        nrow  = row;
        ncol  = col;
        valid = 1'b0;
        case (dir)
            2'd0: begin nrow = row - RW'(1); valid = (row != '0); end
            2'd1: begin ncol = col + CW'(1); valid = (col != CW'(COLS - 1)); end
            2'd2: begin nrow = row + RW'(1); valid = (row != RW'(ROWS - 1)); end
            default: begin ncol = col - CW'(1); valid = (col != '0); end
        endcase
    end
endmodule

// File: rtl/nps_bist_ctrl.sv
module nps_bist_ctrl
    import nps_pkg::*;
#(
    parameter int  ROWS = 8,
    parameter int  COLS = 8,
    localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW   = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int AW   = RW + CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic          mem_wdata,
    input  logic          mem_rdata,
    output logic          done,
    output logic          pass,
    output logic          fail,
    output logic [RW-1:0] fail_row,
    output logic [CW-1:0] fail_col,
    output logic          fail_exp,
    output logic [3:0]    fail_pat
);
    typedef struct packed {
        nps_state_e    st;
        logic [RW-1:0] row;
        logic [CW-1:0] col;
        logic          grp;
        logic          hold;
        logic [4:0]    slot;
        logic [2:0]    op;
        logic          pend;
        logic          pexp;
        logic [RW-1:0] prow;
        logic [CW-1:0] pcol;
        logic [3:0]    ppat;
        logic [RW-1:0] frow;
        logic [CW-1:0] fcol;
        logic          fexp;
        logic [3:0]    fpat;
        logic          pass;
        logic          fail;
    } nps_reg_t;

    nps_reg_t r_q, r_d;

    logic [3:0]    pat_w;
    logic [1:0]    dir_w;
    logic [RW-1:0] nrow_w;
    logic [CW-1:0] ncol_w;
    logic          nvalid_w;

    nps_gray_step u_gray (
        .slot (r_q.slot),
        .pat  (pat_w),
        .dir  (dir_w)
    );

    nps_nbr_sel #(.ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW)) u_nbr (
        .row   (r_q.row),
        .col   (r_q.col),
        .dir   (dir_w),
        .nrow  (nrow_w),
        .ncol  (ncol_w),
        .valid (nvalid_w)
    );

    logic miss_w, last_cell_w, is_base_w, adv_w;

    always_comb begin
        r_d       = r_q;
        r_d.pend  = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = 1'b0;
        mem_addr  = {r_q.row, r_q.col};
        adv_w     = 1'b0;

        miss_w      = r_q.pend && (mem_rdata != r_q.pexp);
        last_cell_w = (r_q.row == RW'(ROWS - 1)) && (r_q.col == CW'(COLS - 1));
        is_base_w   = ((r_q.row[0] ^ r_q.col[0]) == r_q.grp);

        case (r_q.st)
            ST_INIT: begin
                mem_we = 1'b1;
                adv_w  = 1'b1;
            end
            ST_RUN: begin
                if (miss_w) begin
                    r_d.st   = ST_FAIL;
                    r_d.fail = 1'b1;
                    r_d.frow = r_q.prow;
                    r_d.fcol = r_q.pcol;
                    r_d.fexp = r_q.pexp;
                    r_d.fpat = r_q.ppat;
                end else if (!is_base_w) begin
                    adv_w = 1'b1;
                end else if (r_q.slot == SLOT_PRE) begin
                    mem_we    = 1'b1;
                    mem_wdata = r_q.hold;
                    r_d.slot  = 5'd1;
                    r_d.op    = '0;
                end else if (r_q.slot == SLOT_POST) begin
                    mem_we = 1'b1;
                    adv_w  = 1'b1;
                end else begin
                    case (nps_op_e'(r_q.op))
                        OP_NBR_WR: begin
                            mem_we    = nvalid_w;
                            mem_addr  = {nrow_w, ncol_w};
                            mem_wdata = pat_w[dir_w];
                        end
                        OP_WR_FLIP: begin
                            mem_we    = 1'b1;
                            mem_wdata = !r_q.hold;
                        end
                        OP_WR_BACK: begin
                            mem_we    = 1'b1;
                            mem_wdata = r_q.hold;
                        end
                        default: begin
                            r_d.pend = 1'b1;
                            r_d.pexp = (nps_op_e'(r_q.op) == OP_RD_FLIP) ? !r_q.hold : r_q.hold;
                            r_d.prow = r_q.row;
                            r_d.pcol = r_q.col;
                            r_d.ppat = pat_w;
                        end
                    endcase
                    if (nps_op_e'(r_q.op) == OP_RD_BACK) begin
                        r_d.op = '0;
                        if (r_q.slot != SLOT_LAST) begin
                            r_d.slot = r_q.slot + 5'd1;
                        end else if (!r_q.hold) begin
                            r_d.hold = 1'b1;
                            r_d.slot = SLOT_PRE;
                        end else begin
                            r_d.slot = SLOT_POST;
                        end
                    end else begin
                        r_d.op = r_q.op + 3'd1;
                    end
                end
            end
            default: begin
                if (start) begin
                    r_d.st   = ST_INIT;
                    r_d.row  = '0;
                    r_d.col  = '0;
                    r_d.pass = 1'b0;
                    r_d.fail = 1'b0;
                end
            end
        endcase

        if (adv_w) begin
            r_d.hold = 1'b0;
            r_d.slot = SLOT_PRE;
            r_d.op   = '0;
            if (r_q.col == CW'(COLS - 1)) begin
                r_d.col = '0;
                r_d.row = r_q.row + RW'(1);
            end else begin
                r_d.col = r_q.col + CW'(1);
            end
            if (last_cell_w) begin
                r_d.row = '0;
                if (r_q.st == ST_INIT) begin
                    r_d.st  = ST_RUN;
                    r_d.grp = 1'b0;
                end else if (!r_q.grp) begin
                    r_d.grp = 1'b1;
                end else begin
                    r_d.st   = ST_DONE;
                    r_d.pass = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign done     = (r_q.st == ST_DONE) || (r_q.st == ST_FAIL);
    assign pass     = r_q.pass;
    assign fail     = r_q.fail;
    assign fail_row = r_q.frow;
    assign fail_col = r_q.fcol;
    assign fail_exp = r_q.fexp;
    assign fail_pat = r_q.fpat;

    AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && fail)); // R7
    AST_WR_IN_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (int'(mem_addr[AW-1:CW]) < ROWS && int'(mem_addr[CW-1:0]) < COLS)); // R6
    AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_we); // R8
    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> fail); // R7
    AST_PASS_HAS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done); // R8
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (!done && !pass && !fail)); // R9

endmodule

// File: tb/test_nps_bist_ctrl.sv
module test_nps_bist_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS = 6;
    localparam int COLS = 5;
    localparam int RW = 3;
    localparam int CW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [RW+CW-1:0] mem_addr;
    logic mem_we, mem_wdata, mem_rdata;
    logic done, pass, fail, fail_exp;
    logic [RW-1:0] fail_row;
    logic [CW-1:0] fail_col;
    logic [3:0] fail_pat;

    int n_chk = 0;
    int n_bad = 0;
    int wr_total = 0;
    int oob_total = 0;
    int fault_kind = 0;
    int fr = 0;
    int fc = 0;
    logic mem [0:63];

    always #(CLK_PERIOD/2) clk = ~clk;

    nps_bist_ctrl #(.ROWS(ROWS), .COLS(COLS)) i_nps_bist_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .pass(pass), .fail(fail),
        .fail_row(fail_row), .fail_col(fail_col), .fail_exp(fail_exp), .fail_pat(fail_pat)
    );

    function automatic logic [5:0] ad(input int r, input int c);
        return {3'(r), 3'(c)};
    endfunction

    function automatic logic rd_val(input logic [5:0] a);
        logic v;
        v = mem[a];
        if (a == ad(fr, fc)) begin
            if (fault_kind == 1) v = 1'b1;
            if (fault_kind == 2) v = 1'b0;
            if (fault_kind == 3 && mem[ad(fr-1, fc)] && mem[ad(fr+1, fc)]
                && !mem[ad(fr, fc+1)] && !mem[ad(fr, fc-1)]) v = 1'b1;
        end
        return v;
    endfunction

    // memory model with one injectable fault
    always @(posedge clk) begin
        if (mem_we) begin
            wr_total++;
            if (int'(mem_addr[5:3]) >= ROWS || int'(mem_addr[2:0]) >= COLS) oob_total++;
            if (fault_kind == 4 && mem_addr == ad(fr, fc+1) && mem_wdata && !mem[mem_addr])
                mem[ad(fr, fc)] <= ~mem[ad(fr, fc)];
            mem[mem_addr] <= mem_wdata;
        end
        mem_rdata <= rd_val(mem_addr);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_test(output int cycles);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cycles = 0;
        while (!done && cycles < 20000) begin
            @(negedge clk);
            cycles++;
        end
        check(done, "R8 finish in time", cycles, 20000);
    endtask

    task automatic expect_fault(input int kind, input int r, input int c,
                                input int eexp, input int epat, input string tag);
        int cyc;
        int w0;
        fault_kind = kind; fr = r; fc = c;
        run_test(cyc);
        check(fail && !pass, {tag, " R7 fail flag"}, fail, 1);
        check(fail_row == 3'(r), {tag, " R3 fail row"}, fail_row, r);
        check(fail_col == 3'(c), {tag, " R3 fail col"}, fail_col, c);
        check(fail_exp == 1'(eexp), {tag, " R4 expected bit"}, fail_exp, eexp);
        check(fail_pat == 4'(epat), {tag, " R5 pattern"}, fail_pat, epat);
        w0 = wr_total;
        repeat (20) @(negedge clk);
        check(wr_total == w0, {tag, " R7 no write after stop"}, wr_total - w0, 0);
        check(fail && done, {tag, " R7 result held"}, fail, 1);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!done && !pass && !fail && !mem_we, "R1 reset outputs", {done, pass, fail, mem_we}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(!mem_we && !done && wr_total == 0, "R1 idle without start", wr_total, 0);
    endtask

    task automatic t_clean_pass;
        int cyc;
        int w0;
        int exp_w;
        int o0;
        fault_kind = 0;
        exp_w = ROWS * COLS;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                int nb;
                nb = 8 * (r > 0) + 4 * (c < COLS-1) + 2 * (r < ROWS-1) + 2 * (c > 0);
                exp_w += 67 + 2 * nb;
            end
        end
        w0 = wr_total;
        o0 = oob_total;
        run_test(cyc);
        check(pass && !fail, "R8 clean array passes", pass, 1);
        check(wr_total - w0 == exp_w, "R4 R5 total write count", wr_total - w0, exp_w);
        check(oob_total == o0, "R6 no write outside array", oob_total - o0, 0);
        for (int a = 0; a < 8; a++) begin
            check(mem[ad(a / 4, a % 4)] == 1'b0, "R4 cells left at 0", mem[ad(a / 4, a % 4)], 0);
        end
    endtask

    task automatic t_init_clears;
        int cyc;
        mem[ad(1, 1)] = 1'b1;
        mem[ad(4, 3)] = 1'b1;
        fault_kind = 0;
        run_test(cyc);
        check(pass, "R2 R9 fill clears stale ones, rerun after pass", pass, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_clean_pass();
        expect_fault(1, 0, 0, 0, 4'b0001, "corner stuck1");
        expect_fault(1, 2, 2, 0, 4'b0001, "group0 stuck1");
        expect_fault(2, 3, 4, 1, 4'b0001, "group1 stuck0");
        expect_fault(1, 5, 4, 0, 4'b0001, "last corner R9 rerun");
        expect_fault(3, 2, 3, 0, 4'b0101, "static NS");
        expect_fault(4, 4, 1, 0, 4'b0011, "active east rise");
        t_init_clears();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule